// File: doc/BRIEF.md
# Least-Recently-Used Bus Arbiter

This block decides which of N bus masters owns the shared bus in the next bus cycle. It keeps a ranked list holding every master index exactly once. The top of the list has the most priority. When requests collide, the grant goes to the requesting master that ranks highest. Because the list is reordered after every grant, the master that has gone longest without the bus always wins, and the master that used it last always loses.

The decision is pure combinational logic from the request vector and the stored list, so it settles within the bus cycle in which the requests are presented. A strobe marks the end of each bus cycle. On that strobe, if a grant was valid, the winning master is taken out of its slot and placed at the bottom of the list. The masters that were below it each move up one place, and the masters that were above it stay where they are.

Typical use: the bus controller presents the request lines. It reads the one-hot grant and the valid flag during the cycle, and it pulses the advance strobe once the bus cycle completes.

Top module: `lru_bus_arbiter`

## Requirements
- R1: A synchronous reset, active low, sets the list to master 0 at the top, then master 1 and onward, down to master N-1 at the bottom.
- R2: In the same cycle as the requests, `grant` is one-hot with bit i set for the requesting master that ranks highest in the current list.
- R3: `grant_valid` is 1 exactly when at least one request bit is 1. With no requests, `grant` is all zeros.
- R4: On a clock edge where `advance` is 1 and `grant_valid` is 1, the granted master moves to the bottom of the list. Masters ranked below it each rise by one place, and masters ranked above it keep their places.
- R5: An `advance` while no master requests leaves the list unchanged.
- R6: Without `advance`, the list holds its order, no matter how the requests change.
- R7: The list is always a permutation of 0..N-1.
- R8: A master that holds its request continuously is granted within N consecutive advances.
- R9: No master is granted unless its request bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | N | Request lines, bit i for master i |
| advance | input | 1 | End-of-bus-cycle strobe; commits the current grant into the list |
| grant | output | N | One-hot grant, bit i for master i |
| grant_valid | output | 1 | High while any master is granted |

## Verification
All masters requesting at once, with advance pulses, walks the whole list. This shows both the reset order and the move-to-bottom rotation. A single requester, followed by pairs of requesters, separates true least-recently-used ordering from a rotating pointer: after a lone grant to master 2, a contest between masters 2 and 3 must go to 3, and master 0 must still beat both. Long random request patterns, checked against a queue model, exercise reordering from arbitrary positions in the list. One master held high against random contenders measures the worst-case wait. Idle advances, and request changes without advances, show that the list is left untouched.

// File: rtl/lru_arb_pkg.sv
`timescale 1ns/1ps
// Package: shared helpers for the least-recently-used arbiter.
// Assumes: parameter values are small positive integers.
package lru_arb_pkg;

    // Width of an index into a list of n entries; at least one bit.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/lru_order_list.sv
`timescale 1ns/1ps
// Module: lru_order_list
// Holds the ranked list of master indices, with position 0 at the top.
// When upd_en is set, the entry at win_pos is moved to the bottom and the
// entries below it rise by one place. Entries above it stay put.
// Assumes: win_pos < N whenever upd_en is set.
module lru_order_list #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_en,
    input  logic [IW-1:0]   win_pos,
    output logic [N*IW-1:0] list_flat
);

    logic [IW-1:0] ent_q [N];
    logic [IW-1:0] ent_d [N];
    logic [IW-1:0] mover;

    // Index of the master that leaves its slot on this update.
    always_comb mover = ent_q[win_pos];

    for (genvar p = 0; p < N; p++) begin : g_slot
        if (p == N - 1) begin : g_bottom
            // The bottom slot receives the mover on an update.
            always_comb ent_d[p] = upd_en ? mover : ent_q[p];
        end else begin : g_mid
            // Slots at or below the winner take their lower neighbour's entry.
            always_comb begin
                if (upd_en && (IW'(p) >= win_pos))
                    ent_d[p] = ent_q[p+1];
                else
                    ent_d[p] = ent_q[p];
            end
        end

        // Slot register: reset to the identity order, otherwise load the next value.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q[p] <= IW'(p);
            else
                ent_q[p] <= ent_d[p];
        end

        // Expose the slot on the flat bus, top of the list in the low bits.
        assign list_flat[p*IW +: IW] = ent_q[p];
    end

endmodule

// File: rtl/lru_pick.sv
`timescale 1ns/1ps
// Module: lru_pick
// Purely combinational resolver. It maps each list position to that
// master's request, picks the highest-ranked position with a request,
// and drives a one-hot grant.
// Assumes: list_flat holds a permutation of 0..N-1.
module lru_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]    req,
    input  logic [N*IW-1:0] list_flat,
    output logic [N-1:0]    grant,
    output logic            valid,
    output logic [IW-1:0]   win_pos
);

    logic [N-1:0]  hit;
    logic [IW-1:0] win_idx;

    for (genvar p = 0; p < N; p++) begin : g_hit
        // Is the master ranked at position p requesting?
        assign hit[p] = req[list_flat[p*IW +: IW]];
    end

    // Priority encoder: the smallest position with a hit wins.
    always_comb begin
        win_pos = '0;
        for (int p = N - 1; p >= 0; p--) begin
            if (hit[p]) win_pos = IW'(p);
        end
    end

    // Look up the winning master index and form the one-hot grant.
    always_comb begin
        valid   = |hit;
        win_idx = list_flat[win_pos*IW +: IW];
        grant   = valid ? (N'(1) << win_idx) : '0;
    end

endmodule

// File: rtl/lru_bus_arbiter.sv
`timescale 1ns/1ps
// Module: lru_bus_arbiter (top)
// Central least-recently-used arbiter for N bus masters. The grant is
// combinational from req and the stored list. The list is reordered on
// an advance strobe while a grant is valid.
// Assumes: advance is sampled on the rising clock edge that ends a bus cycle.
module lru_bus_arbiter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         advance,
    output logic [N-1:0] grant,
    output logic         grant_valid
);

    localparam int IW = lru_arb_pkg::idx_bits(N);

    logic [N*IW-1:0] list_flat;
    logic [IW-1:0]   win_pos;
    logic            upd_en;

    // Commit the grant only when the cycle ends and someone actually won.
    assign upd_en = advance & grant_valid;

    lru_order_list #(.N(N), .IW(IW)) u_list (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (upd_en),
        .win_pos   (win_pos),
        .list_flat (list_flat)
    );

    lru_pick #(.N(N), .IW(IW)) u_pick (
        .req       (req),
        .list_flat (list_flat),
        .grant     (grant),
        .valid     (grant_valid),
        .win_pos   (win_pos)
    );

endmodule

// File: rtl/lru_arb_checker.sv
`timescale 1ns/1ps
// Module: lru_arb_checker
// Property checks for lru_bus_arbiter. It is attached with bind and
// observes the ports and the stored list.
// Assumes: N is below 64.
module lru_arb_checker #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N-1:0]    req,
    input logic            advance,
    input logic [N-1:0]    grant,
    input logic            grant_valid,
    input logic [N*IW-1:0] list_flat
);

    localparam int SW = 1 << IW;
    localparam int CW = $clog2(N + 1) + 1;
    localparam logic [SW-1:0] FULL = SW'((64'd1 << N) - 64'd1);

    logic [SW-1:0] seen;
    logic [IW-1:0] g_idx;

    // Mark every master index present in the list.
    always_comb begin
        seen = '0;
        for (int p = 0; p < N; p++) seen[list_flat[p*IW +: IW]] = 1'b1;
    end

    // Encode the one-hot grant back to an index.
    always_comb begin
        g_idx = '0;
        for (int i = 0; i < N; i++) if (grant[i]) g_idx = IW'(i);
    end

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R3
    valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid == (|req) && (grant_valid == (grant != '0)));

    // R9
    grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

    // R7
    list_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen == FULL);

    // R5 R6
    list_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(advance && grant_valid) |=> $stable(list_flat));

    // R4
    winner_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && grant_valid) |=> list_flat[(N-1)*IW +: IW] == $past(g_idx));

    for (genvar i = 0; i < N; i++) begin : g_wait
        logic [CW-1:0] wait_q;

        // Count advances lost by master i while its request stays high.
        always_ff @(posedge clk) begin
            if (!rst_n || !req[i])
                wait_q <= '0;
            else if (advance && grant[i])
                wait_q <= '0;
            else if (advance)
                wait_q <= wait_q + CW'(1);
        end

        // R8
        starve_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wait_q < CW'(N));
    end

endmodule

bind lru_bus_arbiter lru_arb_checker #(.N(N), .IW(IW)) u_lru_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .advance     (advance),
    .grant       (grant),
    .grant_valid (grant_valid),
    .list_flat   (list_flat)
);

// File: tb/lru_bus_arbiter_bench.sv
`timescale 1ns/1ps
module lru_bus_arbiter_bench;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         advance = 1'b0;
    logic [N-1:0] grant;
    logic         grant_valid;

    int n_chk = 0;
    int n_fail = 0;
    int q [N];
    bit done = 0;

    always #10 clk = ~clk;

    lru_bus_arbiter #(.N(N)) u_lru_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .advance(advance),
        .grant(grant), .grant_valid(grant_valid)
    );

    function automatic void model_reset();
        for (int p = 0; p < N; p++) q[p] = p;
    endfunction

    function automatic logic [N-1:0] exp_grant(input logic [N-1:0] r);
        for (int p = 0; p < N; p++) if (r[q[p]]) return N'(1) << q[p];
        return '0;
    endfunction

    function automatic void model_move(input logic [N-1:0] r);
        int pos = -1;
        int w;
        for (int p = 0; p < N; p++) if (pos < 0 && r[q[p]]) pos = p;
        if (pos < 0) return;
        w = q[pos];
        for (int p = pos; p < N - 1; p++) q[p] = q[p+1];
        q[N-1] = w;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Drive one bus cycle, check the combinational result, update the model.
    task automatic step(input logic [N-1:0] r, input logic adv, input string tag);
        logic [N-1:0] eg;
        @(negedge clk);
        req = r;
        advance = adv;
        #2;
        eg = exp_grant(r);
        chk(grant === eg, tag, grant, eg);
        chk(grant_valid === (r != '0), "R3", {{(N-1){1'b0}}, grant_valid}, {{(N-1){1'b0}}, r != '0});
        if (adv) model_move(r);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req = '0;
        advance = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        do_reset();
        // R1: identity order after reset, walked by full contention.
        step('1, 1'b0, "R1");
        for (int k = 0; k < N + 1; k++) step('1, 1'b1, "R1");
        // R6: requests change without advance; list must hold.
        step(4'b1100, 1'b0, "R6");
        step(4'b0011, 1'b0, "R6");
        step('1, 1'b0, "R6");
        // R5: idle advances leave the list as it was.
        step('0, 1'b1, "R5");
        step('0, 1'b1, "R5");
        step('1, 1'b0, "R5");
        // R4: lone grant to master 2, then pairs.
        do_reset();
        step(4'b0100, 1'b1, "R4");
        step(4'b1100, 1'b0, "R4");
        step(4'b1101, 1'b0, "R4");
        step(4'b1101, 1'b1, "R4");
        step(4'b0110, 1'b1, "R4");
        step('1, 1'b0, "R4");
        // R1: reset in mid-run restores identity.
        do_reset();
        step('1, 1'b0, "R1");
        // R2 R9: random patterns against the queue model.
        void'($urandom(32'd1234));
        for (int k = 0; k < 2000; k++)
            step(N'($urandom), 1'($urandom_range(0, 3) != 0), "R2");
        // R8: master 3 held high against random contenders.
        for (int k = 0; k < 300; k++) begin
            int waits = 0;
            bit got = 0;
            while (!got && waits <= N) begin
                step(N'($urandom) | 4'b1000, 1'b1, "R8");
                if (grant[3]) got = 1; else waits++;
            end
            chk(got && waits < N, "R8", N'(waits), N'(N - 1));
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule